// File: doc/BRIEF.md
# Sixty-Four Source Interrupt Controller

This block gathers interrupt requests from up to 64 sources into a pair of 32-bit pending words and gates them with a matching pair of 32-bit enable words. It drives one active-high interrupt line towards the processor. A read-only vector word tells software which source to service.

The pending and enable words are split into a high word and a low word. A source number does not select the bit of the same number. Instead, a fixed permutation places each source in one word at one bit position. Software clears pending bits by writing ones to them. It reads the vector to find the lowest-numbered source that is both pending and enabled.

Two priority configuration words are provided as plain storage with fixed reset values. Input sense conditioning happens upstream. Each request input arrives already conditioned:

- A level-type source holds its request high.
- An edge-type source gives a one-cycle pulse.

Top module: `irq_ctrl64`

## Requirements
- R1: After reset, these registers read zero: both pending words, both enable words and the vector word. Both priority words read 0x05309770. `cpu_irq` is low.
- R2: Word selection:
  - Sources 0 to 15 and 32 to 47 live in the high word.
  - Sources 16 to 31 and 48 to 63 live in the low word.
- R3: Bit positions in the high word:
  - Source 0 sits at bit 0.
  - Source s in 1..15 sits at bit 16-s.
  - Source s in 32..47 sits at bit 63-s.
- R4: Bit positions in the low word:
  - Source s in 16..31 sits at bit 31-s.
  - Source s in 48..63 sits at bit s-32.
- R5: Setting and holding a pending bit:
  - A pending bit is set at the first clock edge where its request input is high.
  - The bit stays set after the request drops, until software clears it.
  - A level-type request held high sets the bit again on every cycle.
- R6: Clearing a pending bit:
  - Writing a 1 to a pending bit clears it.
  - Writing a 0 leaves that bit unchanged.
  - Writing all ones clears the whole word.
- R7: If a request and a write-one-to-clear hit the same bit in the same cycle, the bit stays set.
- R8: Enable gating:
  - An enable bit of 1 lets its pending bit drive `cpu_irq`.
  - `cpu_irq` is high exactly when some pending bit and its enable bit are both 1.
  - Pending bits record requests whatever the enable state.
- R9: The vector word works as follows:
  - Bits 31:26 hold the lowest-numbered source that is both pending and enabled.
  - Bits 25:0 are zero.
  - A value of 0 means nothing is active.
- R10: Source 0 is reserved. Its request input is ignored, and its pending bit never becomes set.
- R11: Register map and bus timing:
  - Word addresses: 0 = high pending, 1 = low pending, 2 = high enable, 3 = low enable, 4 = vector (read-only; writes are ignored), 5 = high priority, 6 = low priority.
  - Every other address reads 0 and ignores writes.
  - Read data appears on `bus_rdata` one clock after the read is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 64 | Conditioned request per source, active high |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after a read |
| cpu_irq | output | 1 | Interrupt to the processor, active high |

## Verification
The bench builds the block with its default parameters. With `ADDR_W` = 4, the unmapped addresses 7 to 15 can be reached, so reads and writes there can be checked for having no effect. The default priority reset words are checked as the expected reset contents.

At these values, sources drawn from all four source ranges cover both words and both halves of each word. The vector encoder is exercised with sources from different ranges pending together.

// File: rtl/irq64_pkg.sv
package irq64_pkg;

    localparam int NSRC   = 64;
    localparam int WORD_W = 32;
    localparam int NWORD  = 2;
    localparam int VEC_W  = $clog2(NSRC);
    localparam int VEC_LSB = WORD_W - VEC_W;

    // word index 0 = high word, 1 = low word
    localparam int W_HI = 0;
    localparam int W_LO = 1;

    // register word addresses
    localparam int RA_PEND_BASE = 0;
    localparam int RA_MASK_BASE = 2;
    localparam int RA_VEC       = 4;
    localparam int RA_PRIO_HI   = 5;
    localparam int RA_PRIO_LO   = 6;

    localparam logic [WORD_W-1:0] PRIO_DEFAULT = 32'h0530_9770;

    typedef logic [NWORD-1:0][WORD_W-1:0] word_pair_t;

    // which word holds a source
    function automatic logic src_word(input int s);
        return ((s / 16) % 2) == 1;
    endfunction

    // which bit inside its word holds a source
    function automatic logic [4:0] src_bit(input int s);
        int b;
        if (s < 16)
            b = (s == 0) ? 0 : 16 - s;
        else if (s < 32)
            b = 31 - s;
        else if (s < 48)
            b = 63 - s;
        else
            b = s - 32;
        return b[4:0];
    endfunction

endpackage

// File: rtl/irq64_perm.sv
module irq64_perm
    import irq64_pkg::*;
(
    input  logic [NSRC-1:0] src_req,
    output word_pair_t      set_o
);

    logic unused_src0;
    assign unused_src0 = src_req[0];

    // source 0 is reserved and never scattered into a pending word
    always_comb begin
        set_o = '0;
        for (int s = 1; s < NSRC; s++) begin
            if (src_req[s])
                set_o[src_word(s)][src_bit(s)] = 1'b1;
        end
    end

endmodule

// File: rtl/irq64_word_bank.sv
module irq64_word_bank #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    input  logic             mask_we,
    input  logic [WIDTH-1:0] mask_wd,
    output logic [WIDTH-1:0] pend_o,
    output logic [WIDTH-1:0] mask_o
);

    logic [WIDTH-1:0] pend_q;
    logic [WIDTH-1:0] mask_q;
    logic             armed_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= '0;
            mask_q  <= '0;
            armed_q <= 1'b0;
        end else begin
            // a new request outranks a clear aimed at the same bit
            pend_q  <= (pend_q & ~clr_i) | set_i;
            armed_q <= 1'b1;
            if (mask_we)
                mask_q <= mask_wd;
        end
    end

    assign pend_o = pend_q;
    assign mask_o = mask_q;

    AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> ((pend_q & $past(set_i)) == $past(set_i))); // R7

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> ((pend_q & $past(clr_i & ~set_i)) == '0)); // R6

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (((pend_q | $past(clr_i)) & $past(pend_q)) == $past(pend_q))); // R5

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !$past(mask_we)) |-> $stable(mask_q)); // R8

endmodule

// File: rtl/irq64_vec_enc.sv
module irq64_vec_enc
    import irq64_pkg::*;
(
    input  word_pair_t        act_i,
    output logic [VEC_W-1:0]  vec_o,
    output logic              any_o
);

    // scan downward so the lowest-numbered active source is kept last
    always_comb begin
        vec_o = '0;
        for (int s = NSRC - 1; s >= 1; s--) begin
            if (act_i[src_word(s)][src_bit(s)])
                vec_o = VEC_W'(s);
        end
    end

    assign any_o = |act_i;

endmodule

// File: rtl/irq_ctrl64.sv
module irq_ctrl64
    import irq64_pkg::*;
#(
    parameter int                ADDR_W      = 4,
    parameter logic [WORD_W-1:0] PRIO_HI_RST = PRIO_DEFAULT,
    parameter logic [WORD_W-1:0] PRIO_LO_RST = PRIO_DEFAULT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_req,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              cpu_irq
);

    localparam logic [ADDR_W-1:0] A_VEC     = ADDR_W'(RA_VEC);
    localparam logic [ADDR_W-1:0] A_PRIO_HI = ADDR_W'(RA_PRIO_HI);
    localparam logic [ADDR_W-1:0] A_PRIO_LO = ADDR_W'(RA_PRIO_LO);

    logic wr_en;
    logic rd_en;
    assign wr_en = bus_sel &  bus_we;
    assign rd_en = bus_sel & ~bus_we;

    word_pair_t set_w;
    word_pair_t clr_w;
    word_pair_t pend_w;
    word_pair_t mask_w;
    word_pair_t act_w;

    irq64_perm u_perm (
        .src_req (src_req),
        .set_o   (set_w)
    );

    for (genvar w = 0; w < NWORD; w++) begin : g_word
        localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(RA_PEND_BASE + w);
        localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(RA_MASK_BASE + w);

        logic mask_we_w;
        assign mask_we_w = wr_en && (bus_addr == A_MASK);
        assign clr_w[w]  = (wr_en && (bus_addr == A_PEND)) ? bus_wdata : '0;

        irq64_word_bank #(.WIDTH(WORD_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_i   (set_w[w]),
            .clr_i   (clr_w[w]),
            .mask_we (mask_we_w),
            .mask_wd (bus_wdata),
            .pend_o  (pend_w[w]),
            .mask_o  (mask_w[w])
        );

        assign act_w[w] = pend_w[w] & mask_w[w];
    end

    logic [VEC_W-1:0] vec_num;
    logic             any_act;

    irq64_vec_enc u_enc (
        .act_i (act_w),
        .vec_o (vec_num),
        .any_o (any_act)
    );

    logic [WORD_W-1:0] prio_hi_q;
    logic [WORD_W-1:0] prio_lo_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_hi_q <= PRIO_HI_RST;
            prio_lo_q <= PRIO_LO_RST;
        end else if (wr_en) begin
            if (bus_addr == A_PRIO_HI) prio_hi_q <= bus_wdata;
            if (bus_addr == A_PRIO_LO) prio_lo_q <= bus_wdata;
        end
    end

    logic [WORD_W-1:0] rd_mux;

    always_comb begin
        case (int'(bus_addr))
            RA_PEND_BASE:     rd_mux = pend_w[W_HI];
            RA_PEND_BASE + 1: rd_mux = pend_w[W_LO];
            RA_MASK_BASE:     rd_mux = mask_w[W_HI];
            RA_MASK_BASE + 1: rd_mux = mask_w[W_LO];
            RA_VEC:           rd_mux = {vec_num, {VEC_LSB{1'b0}}};
            RA_PRIO_HI:       rd_mux = prio_hi_q;
            RA_PRIO_LO:       rd_mux = prio_lo_q;
            default:          rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (rd_en)
            bus_rdata <= rd_mux;
    end

    assign cpu_irq = any_act;

    AST_IRQ_VEC_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq == (vec_num != '0)); // R9

    AST_SRC0_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        pend_w[W_HI][0] == 1'b0); // R10

    AST_VEC_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == A_VEC) |=> ($stable(prio_hi_q) && $stable(prio_lo_q))); // R11

endmodule

// File: tb/tb_irq_ctrl64.sv
`timescale 1ns/1ps
module tb_irq_ctrl64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src_req = '0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cpu_irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_ctrl64 #(.ADDR_W(4)) dut (
        .clk(clk), .rst_n(rst_n), .src_req(src_req),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_irq(cpu_irq)
    );

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } rd_item_t;

    rd_item_t exp_q[$];
    logic     rd_issued = 1'b0;

    // expected placement per the map requirements R2, R3 and R4
    function automatic int tb_word(input int s);
        return ((s >= 16 && s < 32) || s >= 48) ? 1 : 0;
    endfunction

    function automatic logic [31:0] tb_bitval(input int s);
        int b;
        if (s == 0)      b = 0;
        else if (s < 16) b = 16 - s;
        else if (s < 32) b = 31 - s;
        else if (s < 48) b = 63 - s;
        else             b = s - 32;
        return 32'd1 << b;
    endfunction

    always @(posedge clk) rd_issued <= bus_sel & ~bus_we;

    // monitor: compares each completed read against the scoreboard
    always @(negedge clk) begin
        if (rd_issued) begin
            rd_item_t it;
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R11 unexpected read data actual=%08h expected=none", bus_rdata);
            end else begin
                it = exp_q.pop_front();
                if (bus_rdata !== it.exp) begin
                    failures++;
                    $display("FAIL %s actual=%08h expected=%08h", it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic rd(input int a, input logic [31:0] e, input string tag);
        rd_item_t it;
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 4'(a);
        it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 4'(a); bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic pulse(input int s, input int n);
        @(negedge clk);
        src_req[s] = 1'b1;
        repeat (n) @(negedge clk);
        src_req[s] = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        checks++;
        if (cpu_irq !== e) begin
            failures++;
            $display("FAIL %s cpu_irq actual=%0b expected=%0b", tag, cpu_irq, e);
        end
    endtask

    task automatic clr_all();
        wr(0, 32'hFFFF_FFFF);
        wr(1, 32'hFFFF_FFFF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int srcs[10] = '{1, 5, 15, 16, 20, 31, 40, 47, 50, 63};
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk_irq(1'b0, "R1");
        rd(0, 32'h0, "R1 pend hi");
        rd(1, 32'h0, "R1 pend lo");
        rd(2, 32'h0, "R1 mask hi");
        rd(3, 32'h0, "R1 mask lo");
        rd(4, 32'h0, "R1 vector");
        rd(5, 32'h0530_9770, "R1 prio hi");
        rd(6, 32'h0530_9770, "R1 prio lo");

        // R2 R3 R4 placement of each source
        foreach (srcs[i]) begin
            int s = srcs[i];
            int w = tb_word(s);
            pulse(s, 1);
            rd(w, tb_bitval(s), $sformatf("R3/R4 src %0d bit", s));
            rd(1 - w, 32'h0, $sformatf("R2 src %0d other word", s));
            clr_all();
        end

        // R5 sticky after request drops
        pulse(5, 1);
        repeat (3) @(negedge clk);
        rd(0, tb_bitval(5), "R5 sticky");
        // R6 zero write has no effect, one clears only its bit
        pulse(40, 1);
        wr(0, 32'h0);
        rd(0, tb_bitval(5) | tb_bitval(40), "R6 zero write");
        wr(0, tb_bitval(5));
        rd(0, tb_bitval(40), "R6 single clear");
        wr(0, 32'hFFFF_FFFF);
        rd(0, 32'h0, "R6 all ones");

        // R7 request and clear in the same cycle
        @(negedge clk);
        src_req[7] = 1'b1;
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 4'd0; bus_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        src_req[7] = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
        rd(0, tb_bitval(7), "R7 set wins");
        clr_all();

        // R5 level request held across a clear
        @(negedge clk);
        src_req[33] = 1'b1;
        wr(0, 32'hFFFF_FFFF);
        rd(0, tb_bitval(33), "R5 level re-set");
        @(negedge clk);
        src_req[33] = 1'b0;
        wr(0, 32'hFFFF_FFFF);
        rd(0, 32'h0, "R5 level released");

        // R8 enable gating
        pulse(20, 1);
        @(negedge clk);
        chk_irq(1'b0, "R8 masked");
        rd(4, 32'h0, "R9 masked vector");
        rd(1, tb_bitval(20), "R8 pending while masked");
        wr(3, tb_bitval(20));
        chk_irq(1'b1, "R8 enabled");
        rd(4, {6'd20, 26'd0}, "R9 single");
        wr(3, 32'h0);
        chk_irq(1'b0, "R8 disabled again");
        clr_all();

        // R9 lowest-numbered active source wins
        wr(2, 32'hFFFF_FFFF);
        wr(3, 32'hFFFF_FFFF);
        @(negedge clk);
        src_req[40] = 1'b1; src_req[20] = 1'b1; src_req[63] = 1'b1;
        @(negedge clk);
        src_req = '0;
        rd(4, {6'd20, 26'd0}, "R9 lowest of three");
        wr(1, tb_bitval(20));
        rd(4, {6'd40, 26'd0}, "R9 next");
        wr(0, tb_bitval(40));
        rd(4, {6'd63, 26'd0}, "R9 last");
        wr(1, 32'hFFFF_FFFF);
        rd(4, 32'h0, "R9 none");
        chk_irq(1'b0, "R9 idle");

        // R10 source 0 ignored even with everything enabled
        pulse(0, 3);
        @(negedge clk);
        chk_irq(1'b0, "R10 src0");
        rd(0, 32'h0, "R10 pend hi");
        rd(4, 32'h0, "R10 vector");

        // R11 map details
        wr(4, 32'hFFFF_FFFF);
        rd(4, 32'h0, "R11 vector read-only");
        wr(5, 32'h1234_5678);
        rd(5, 32'h1234_5678, "R11 prio hi rw");
        rd(6, 32'h0530_9770, "R11 prio lo untouched");
        wr(9, 32'h0);
        rd(9, 32'h0, "R11 unmapped reads zero");
        rd(2, 32'hFFFF_FFFF, "R11 unmapped write ignored");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule